// File: doc/BRIEF.md
# Fast Page Mode DRAM Controller

This block sits between a synchronous requester and an asynchronous fast page mode DRAM array. It takes single-word read and write requests over a valid/ready handshake. Each request becomes a sequence of row strobe, column strobe, write enable and output enable transitions on a multiplexed address bus. The DRAM data bus is split into separate in, out and output-enable signals, so a pad ring or a model can join them.

After an access the row stays open. A later request to the same row is served as a column-only page cycle. A request to another row, a refresh request or the row-open time limit makes the controller raise the row strobe and wait out the precharge time before it opens a new row. Every analogue timing minimum is given as a number of controller clock cycles. Writes always use the early-write form: write enable falls before the column strobe, so the DRAM never drives its outputs during a write. Reads return their word in request order with a one-cycle valid pulse. The refresh schedule is left to a separate agent. This controller only closes the bank and reports when the bank is idle and precharged.

Top module: `fpm_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `dram_ras_n`, `dram_cas_n`, `dram_we_n` and `dram_oe_n` are 1, and `dram_dq_oe`, `rd_valid`, `req_ready` and `ref_ack` are 0.
- R2: The row strobe falls only after it has been high for at least `T_RP` cycles. The row address (request bits `[ROW_W+COL_W-1:COL_W]`, on `dram_addr[ROW_W-1:0]`) is present in the cycle before the fall and for `T_RCD` cycles after it. The first column strobe of a row falls no earlier than `T_RCD+1` cycles after the row strobe.
- R3: A request whose row equals the open row is served without any row strobe transition, as a column-only cycle.
- R4: A request to a different row closes the open row, waits out the precharge of R2, activates the new row and then completes the access with the right data.
- R5: The column strobe is low only while the row strobe is low. It stays low for at least `T_CAS` cycles and high for at least `T_CP` cycles between accesses. The column address (request bits `[COL_W-1:0]`) is on `dram_addr` in the cycle before the column strobe falls and for as long as it stays low.
- R6: In a write, `dram_we_n` is 0 in the cycle before the column strobe falls and while it is low. The write data is driven (`dram_dq_oe`=1) from before that fall until the strobe rises, and `dram_oe_n` stays 1.
- R7: A read samples `dram_dq_in` at the clock edge that ends a column-strobe-low period of max(`T_CAS`,`T_ACC`) cycles. It returns that word on `rd_data` with `rd_valid` high for exactly one cycle.
- R8: `dram_dq_oe` is never 1 while `dram_oe_n` is 0. It rises only after at least `T_OFF` cycles in which the DRAM outputs were not enabled (column strobe and output enable not both low).
- R9: The row strobe never stays low for more than `T_RAS_MAX` consecutive cycles. This holds under a steady stream of page hits and with an open row left idle.
- R10: While `ref_req` is 1, no request is accepted and the open row is closed. `ref_ack` is 1 only when the row strobe is high and has been high for at least `T_RP` cycles.
- R11: The row strobe rises only after it has been low for at least `T_RAS` cycles.
- R12: Every accepted read returns exactly one `rd_valid` pulse, in acceptance order, and a read returns the data of the last accepted write to the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Word address, row in the upper bits |
| req_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | One-cycle read return strobe |
| rd_data | output | DATA_W | Read return data |
| ref_req | input | 1 | Refresh agent asks for the bank |
| ref_ack | output | 1 | Bank closed and precharged |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | DATA_W | Write data toward the DRAM |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | DATA_W | Data returned by the DRAM |

## Verification
Directed sequences separate a same-row follow-up (no new row strobe edge) from a row change (one close, one precharge, one activation). A read followed at once by a write shows whether the bus turnaround wait is kept. A long stream of hits and an idle open row each show the forced close. A refresh request raised while a hit is waiting shows that requests are held back. Random traffic then mixes reads and writes over a few rows, including the highest row, with occasional refresh requests. A cycle-level DRAM model checks the strobe spacing and delays read data until the access time has passed, so early sampling returns corrupted words.

// File: rtl/fpm_pkg.sv
// Package: shared state encoding and constant helpers for the controller.
package fpm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,    // row closed, RAS high, precharging
        ST_ROWSET,  // row address on the bus, RAS still high
        ST_RCD,     // RAS low, row address held
        ST_COLSET,  // column address (and write data) set up, CAS high
        ST_CASLO,   // CAS low
        ST_CASHI,   // CAS precharge
        ST_OPEN     // row open, waiting for the next hit
    } fpm_state_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fpm_span_ctr.sv
// Saturating span counter. It counts the clock cycles since the last cycle
// in which clr was high, and stops at MAXV. Reset clears it to zero.
// Assumes MAXV >= 1.
module fpm_span_ctr #(
    parameter int MAXV = 7,
    localparam int W = $clog2(MAXV + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] q
);

    // Count up from the last clear, holding at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            q <= '0;
        else if (q != W'(MAXV))
            q <= q + 1'b1;
    end

endmodule

// File: rtl/fpm_row_track.sv
// Open-row tracker. It holds the row that is active in the DRAM and flags a
// request whose row matches it. load captures a new row at activation and
// drop forgets it when the row is closed.
module fpm_row_track #(
    parameter int ROW_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [ROW_W-1:0] load_row,
    input  logic             drop,
    input  logic [ROW_W-1:0] cmp_row,
    output logic [ROW_W-1:0] open_row,
    output logic             hit
);

    logic valid;

    // Remember the activated row and whether it is still open.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid    <= 1'b0;
            open_row <= '0;
        end else if (load) begin
            valid    <= 1'b1;
            open_row <= load_row;
        end else if (drop) begin
            valid    <= 1'b0;
        end
    end

    // Page hit when a row is open and its address matches.
    always_comb hit = valid && (open_row == cmp_row);

endmodule

// File: rtl/fpm_ctrl.sv
// Fast page mode DRAM controller, top level.
// It turns single-word requests into RAS/CAS/WE/OE sequences on a multiplexed
// address bus. It keeps the row open for page hits and closes it on a miss,
// on a refresh request, or before the RAS-low limit is reached. All timing
// parameters are in clock cycles. Assumes every T_* >= 1, T_RCD >= 1,
// T_RAS_MAX well above T_RAS + T_RCD plus one page cycle, and a DRAM whose
// outputs are enabled only while CAS and OE are both low.
module fpm_ctrl
    import fpm_pkg::*;
#(
    parameter int DATA_W    = 72,
    parameter int ROW_W     = 12,
    parameter int COL_W     = 10,
    parameter int T_RP      = 5,
    parameter int T_RAS     = 9,
    parameter int T_RCD     = 2,
    parameter int T_CAS     = 2,
    parameter int T_CP      = 2,
    parameter int T_ACC     = 4,
    parameter int T_OFF     = 3,
    parameter int T_RAS_MAX = 12500,
    localparam int ADDR_W   = ROW_W + COL_W,
    localparam int MA_W     = max2(ROW_W, COL_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    input  logic              ref_req,
    output logic              ref_ack,
    output logic [MA_W-1:0]   dram_addr,
    output logic              dram_ras_n,
    output logic              dram_cas_n,
    output logic              dram_we_n,
    output logic              dram_oe_n,
    output logic [DATA_W-1:0] dram_dq_out,
    output logic              dram_dq_oe,
    input  logic [DATA_W-1:0] dram_dq_in
);

    localparam int CAS_RD   = max2(T_CAS, T_ACC);
    localparam int PAGE_MAX = 1 + T_OFF + CAS_RD + T_CP;
    localparam int ST_MAX   = max2(T_RCD, max2(CAS_RD, T_CP));
    localparam int ST_W     = $clog2(ST_MAX + 1);
    localparam int RP_W     = $clog2(T_RP + 1);
    localparam int RL_W     = $clog2(T_RAS_MAX + 1);
    localparam int TA_W     = $clog2(T_OFF + 1);

    fpm_state_e        state, state_n;
    logic              wr_q;
    logic [COL_W-1:0]  col_q;
    logic [DATA_W-1:0] wdata_q;
    logic [ROW_W-1:0]  open_row;
    logic              hit, accept, ras_low, rd_win, rd_take;
    logic [ST_W-1:0]   st_q;
    logic [RP_W-1:0]   rp_q;
    logic [RL_W-1:0]   rl_q;
    logic [TA_W-1:0]   ta_q;
    logic              rp_go, rp_ack, ras_min_ok, fit_page, ta_ok;
    logic              rcd_done, cas_done, cp_done, want_close;

    // Strobe-phase decode shared by the counters and the pins.
    always_comb begin
        ras_low = (state != ST_IDLE) && (state != ST_ROWSET);
        rd_win  = (state == ST_CASLO) && !wr_q;
    end

    // Cycle counters: time in state, RAS high, RAS low, since last read window.
    fpm_span_ctr #(.MAXV(ST_MAX)) u_st_ctr (
        .clk(clk), .rst_n(rst_n), .clr(state_n != state), .q(st_q));
    fpm_span_ctr #(.MAXV(T_RP)) u_rp_ctr (
        .clk(clk), .rst_n(rst_n), .clr(ras_low), .q(rp_q));
    fpm_span_ctr #(.MAXV(T_RAS_MAX)) u_rl_ctr (
        .clk(clk), .rst_n(rst_n), .clr(!ras_low), .q(rl_q));
    fpm_span_ctr #(.MAXV(T_OFF)) u_ta_ctr (
        .clk(clk), .rst_n(rst_n), .clr(rd_win), .q(ta_q));

    // Open-row bookkeeping and hit detection.
    fpm_row_track #(.ROW_W(ROW_W)) u_row (
        .clk(clk), .rst_n(rst_n),
        .load(accept && (state == ST_IDLE)),
        .load_row(req_addr[ADDR_W-1:COL_W]),
        .drop((state == ST_OPEN) && (state_n == ST_IDLE)),
        .cmp_row(req_addr[ADDR_W-1:COL_W]),
        .open_row(open_row), .hit(hit));

    // Timing qualifiers derived from the counters.
    always_comb begin
        rp_go      = 32'(rp_q) + 2 >= T_RP;
        rp_ack     = 32'(rp_q) + 1 >= T_RP;
        ras_min_ok = 32'(rl_q) + 1 >= T_RAS;
        fit_page   = 32'(rl_q) + 2 + PAGE_MAX <= T_RAS_MAX;
        ta_ok      = 32'(ta_q) >= T_OFF;
        rcd_done   = 32'(st_q) == T_RCD - 1;
        cas_done   = wr_q ? (32'(st_q) == T_CAS - 1) : (32'(st_q) == CAS_RD - 1);
        cp_done    = 32'(st_q) == T_CP - 1;
        want_close = ref_req || !fit_page || (req_valid && !hit);
    end

    // Handshake: accept from a precharged idle bank, or as a page hit with room left.
    always_comb begin
        req_ready = !ref_req &&
                    (((state == ST_IDLE) && rp_go) ||
                     ((state == ST_OPEN) && hit && fit_page));
        accept    = req_valid && req_ready;
        ref_ack   = ref_req && (state == ST_IDLE) && rp_ack;
    end

    // Next-state logic of the strobe sequencer.
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:   if (accept) state_n = ST_ROWSET;
            ST_ROWSET: state_n = ST_RCD;
            ST_RCD:    if (rcd_done) state_n = ST_COLSET;
            ST_COLSET: if (!wr_q || ta_ok) state_n = ST_CASLO;
            ST_CASLO:  if (cas_done) state_n = ST_CASHI;
            ST_CASHI:  if (cp_done) state_n = ST_OPEN;
            ST_OPEN: begin
                if (accept)
                    state_n = ST_COLSET;
                else if (want_close && ras_min_ok)
                    state_n = ST_IDLE;
            end
            default:   state_n = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // Capture the accepted request's column, direction and data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            col_q   <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            wr_q    <= req_write;
            col_q   <= req_addr[COL_W-1:0];
            wdata_q <= req_wdata;
        end
    end

    // Read return: sample the DRAM at the end of the CAS-low period.
    always_comb rd_take = rd_win && cas_done;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_take;
            if (rd_take) rd_data <= dram_dq_in;
        end
    end

    // DRAM pin decode from the sequencer state.
    always_comb begin
        dram_ras_n  = !ras_low;
        dram_cas_n  = (state != ST_CASLO);
        dram_we_n   = !(wr_q && ((state == ST_COLSET) || (state == ST_CASLO)));
        dram_oe_n   = !rd_win;
        dram_dq_oe  = wr_q && (((state == ST_COLSET) && ta_ok) || (state == ST_CASLO));
        dram_dq_out = wdata_q;
        dram_addr   = ((state == ST_ROWSET) || (state == ST_RCD)) ?
                      MA_W'(open_row) : MA_W'(col_q);
    end

endmodule

// File: rtl/fpm_ctrl_chk.sv
// Protocol checker for fpm_ctrl. It keeps its own run-length counters of the
// strobes at the pins and checks the spacing rules. It is bound to every
// instance of the controller.
module fpm_ctrl_chk #(
    parameter int T_RP      = 5,
    parameter int T_RAS     = 9,
    parameter int T_CAS     = 2,
    parameter int T_OFF     = 3,
    parameter int T_RAS_MAX = 12500
) (
    input logic clk,
    input logic rst_n,
    input logic dram_ras_n,
    input logic dram_cas_n,
    input logic dram_we_n,
    input logic dram_oe_n,
    input logic dram_dq_oe,
    input logic rd_valid,
    input logic req_ready,
    input logic ref_ack
);

    logic [31:0] lo_q, hi_q, cl_q, gap_q;

    // Run lengths of the previous cycles: RAS low, RAS high, CAS low, DRAM outputs off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0; hi_q <= '0; cl_q <= '0; gap_q <= '0;
        end else begin
            lo_q  <= dram_ras_n ? '0 : lo_q + 1;
            hi_q  <= dram_ras_n ? hi_q + 1 : '0;
            cl_q  <= dram_cas_n ? '0 : cl_q + 1;
            gap_q <= (!dram_cas_n && !dram_oe_n) ? '0 :
                     ((gap_q == 32'hFFFF) ? gap_q : gap_q + 1);
        end
    end

    a_r2_precharge: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_ras_n) |-> hi_q >= T_RP);
    a_r11_ras_min: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_ras_n) |-> lo_q >= T_RAS);
    a_r9_ras_max: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_ras_n |-> lo_q < T_RAS_MAX);
    a_r5_cas_in_row: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_cas_n |-> !dram_ras_n);
    a_r5_cas_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_cas_n) |-> cl_q >= T_CAS);
    a_r6_early_write: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_cas_n) && !dram_we_n) |-> ($past(!dram_we_n) && dram_dq_oe && dram_oe_n));
    a_r8_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        dram_dq_oe |-> dram_oe_n);
    a_r8_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_dq_oe) |-> gap_q >= T_OFF);
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
    a_r10_ack_closed: assert property (@(posedge clk) disable iff (!rst_n)
        ref_ack |-> (dram_ras_n && !req_ready));

endmodule

bind fpm_ctrl fpm_ctrl_chk #(
    .T_RP(T_RP), .T_RAS(T_RAS), .T_CAS(T_CAS), .T_OFF(T_OFF), .T_RAS_MAX(T_RAS_MAX)
) u_chk (
    .clk(clk), .rst_n(rst_n), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
    .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dram_dq_oe(dram_dq_oe),
    .rd_valid(rd_valid), .req_ready(req_ready), .ref_ack(ref_ack)
);

// File: tb/fpm_ctrl_tb.sv
`timescale 1ns/1ps
// Bench: cycle-level DRAM model plus directed and seeded-random request traffic.
module fpm_ctrl_tb;

    localparam int DW = 72, RW = 12, CW = 10, AW = RW + CW;
    localparam int T_RP = 5, T_RAS = 9, T_RCD = 2, T_CAS = 2, T_CP = 2;
    localparam int T_ACC = 4, T_OFF = 3, T_RAS_MAX = 60;

    logic clk = 0, rst_n = 0;
    logic req_valid = 0, req_write = 0, ref_req = 0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, rd_valid, ref_ack;
    logic [DW-1:0] rd_data, dq_out, dq_in;
    logic [RW-1:0] dram_addr;
    logic ras_n, cas_n, we_n, oe_n, dq_oe;

    always #4 clk = ~clk;   // 125 MHz

    fpm_ctrl #(.DATA_W(DW), .ROW_W(RW), .COL_W(CW), .T_RP(T_RP), .T_RAS(T_RAS),
               .T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP), .T_ACC(T_ACC),
               .T_OFF(T_OFF), .T_RAS_MAX(T_RAS_MAX)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .ref_req(ref_req), .ref_ack(ref_ack),
        .dram_addr(dram_addr), .dram_ras_n(ras_n), .dram_cas_n(cas_n),
        .dram_we_n(we_n), .dram_oe_n(oe_n), .dram_dq_out(dq_out),
        .dram_dq_oe(dq_oe), .dram_dq_in(dq_in));

    function automatic logic [DW-1:0] init_word(input logic [AW-1:0] a);
        return {3{{2'b00, a} ^ 24'h5AC3E1}};
    endfunction

    // ---------------- DRAM model and read-return checker ----------------
    logic [DW-1:0] mem [logic [AW-1:0]];
    logic [DW-1:0] exp_q [$];
    int m_checks = 0, m_fail = 0, rd_idx = 0, ras_falls = 0;
    int ras_lo = 0, ras_hi = 0, cas_lo = 0, cas_hi = 100, rw_gap = 1000;
    logic pr_ras = 1, pr_cas = 1, pr_we = 1, pr_oe_dq = 0, first_cas = 0;
    logic [RW-1:0] pr_addr = '0, cur_row = '0;
    logic [CW-1:0] cur_col = '0;

    task automatic mchk(input bit ok, input string tag, input logic [DW-1:0] act, exp);
        m_checks++;
        if (!ok) begin
            m_fail++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [DW-1:0] mem_rd(input logic [AW-1:0] a);
        return mem.exists(a) ? mem[a] : init_word(a);
    endfunction

    initial dq_in = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (pr_ras && !ras_n) begin
                mchk(ras_hi >= T_RP, "R2 precharge before RAS fall", DW'(ras_hi), DW'(T_RP));
                cur_row = dram_addr;
                mchk(pr_addr == dram_addr, "R2 row address set up", DW'(pr_addr), DW'(dram_addr));
                ras_falls++; first_cas = 1;
            end
            if (!ras_n && ras_lo == 1 && cas_n)
                mchk(dram_addr == cur_row, "R2 row address hold", DW'(dram_addr), DW'(cur_row));
            if (!pr_ras && ras_n) begin
                mchk(ras_lo >= T_RAS, "R11 RAS low minimum", DW'(ras_lo), DW'(T_RAS));
                mchk(ras_lo <= T_RAS_MAX, "R9 RAS low maximum", DW'(ras_lo), DW'(T_RAS_MAX));
            end
            if (!ras_n && ras_lo + 1 > T_RAS_MAX)
                mchk(0, "R9 RAS low too long", DW'(ras_lo + 1), DW'(T_RAS_MAX));
            if (pr_cas && !cas_n) begin
                mchk(!ras_n, "R5 CAS only inside row", DW'(ras_n), 0);
                mchk(cas_hi >= T_CP, "R5 CAS precharge", DW'(cas_hi), DW'(T_CP));
                mchk(pr_addr == dram_addr, "R5 column address set up", DW'(pr_addr), DW'(dram_addr));
                if (first_cas)
                    mchk(ras_lo >= T_RCD + 1, "R2 RAS to CAS delay", DW'(ras_lo), DW'(T_RCD + 1));
                first_cas = 0;
                cur_col = dram_addr[CW-1:0];
                if (!we_n) begin
                    mchk(!pr_we && dq_oe && oe_n, "R6 early write form",
                         DW'({pr_we, dq_oe, oe_n}), DW'(3'b011));
                    mem[{cur_row, cur_col}] = dq_out;
                end
            end else if (!cas_n) begin
                mchk(dram_addr[CW-1:0] == cur_col, "R5 column address hold",
                     DW'(dram_addr), DW'(cur_col));
            end
            if (pr_cas == 0 && cas_n)
                mchk(cas_lo >= T_CAS, "R5 CAS low width", DW'(cas_lo), DW'(T_CAS));
            if (dq_oe && !oe_n) mchk(0, "R8 bus contention", 1, 0);
            if (dq_oe && !pr_oe_dq)
                mchk(rw_gap >= T_OFF, "R8 turnaround gap", DW'(rw_gap), DW'(T_OFF));
            if (rd_valid) begin
                if (rd_idx >= exp_q.size()) mchk(0, "R12 unexpected read return", rd_data, 0);
                else begin
                    mchk(rd_data == exp_q[rd_idx], "R7 read data", rd_data, exp_q[rd_idx]);
                    rd_idx++;
                end
            end
        end
        // Drive read data; corrupted until the access time has elapsed.
        if (!cas_n && !oe_n)
            dq_in = (cas_lo + 1 >= T_ACC) ? mem_rd({cur_row, cur_col}) : ~mem_rd({cur_row, cur_col});
        else
            dq_in = {9{8'hA7}};
        ras_lo = ras_n ? 0 : ras_lo + 1;
        ras_hi = ras_n ? ras_hi + 1 : 0;
        cas_lo = cas_n ? 0 : cas_lo + 1;
        cas_hi = cas_n ? cas_hi + 1 : 0;
        rw_gap = (!cas_n && !oe_n) ? 0 : rw_gap + 1;
        pr_ras = ras_n; pr_cas = cas_n; pr_we = we_n; pr_oe_dq = dq_oe; pr_addr = dram_addr;
    end

    // ---------------- Stimulus and directed checks ----------------
    logic [DW-1:0] ref_mem [logic [AW-1:0]];
    int t_checks = 0, t_fail = 0, rd_issued = 0;
    bit done = 0;

    task automatic tchk(input bit ok, input string tag, input logic [DW-1:0] act, exp);
        t_checks++;
        if (!ok) begin
            t_fail++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [DW-1:0] ref_rd(input logic [AW-1:0] a);
        return ref_mem.exists(a) ? ref_mem[a] : init_word(a);
    endfunction

    task automatic issue(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
        if (w) ref_mem[a] = d;
        else begin exp_q.push_back(ref_rd(a)); rd_issued++; end
        @(posedge clk); #1 req_valid = 0;
    endtask

    function automatic logic [DW-1:0] rnd_data();
        logic [95:0] t = {$urandom, $urandom, $urandom};
        return t[DW-1:0];
    endfunction

    function automatic logic [RW-1:0] rnd_row();
        case ($urandom % 4)
            0: return 12'd0;
            1: return 12'd1;
            2: return 12'd2;
            default: return 12'd4095;
        endcase
    endfunction

    initial begin
        int f0, f1;
        void'($urandom(32'd2024));
        repeat (4) @(posedge clk);
        @(negedge clk);
        tchk({ras_n, cas_n, we_n, oe_n} == 4'hF && !dq_oe && !rd_valid && !req_ready && !ref_ack,
             "R1 reset outputs", DW'({ras_n, cas_n, we_n, oe_n, dq_oe, rd_valid, req_ready}),
             DW'(7'b1111000));
        @(posedge clk); #1 rst_n = 1;
        @(negedge clk);
        tchk(ras_n && cas_n && we_n && oe_n && !dq_oe && !req_ready && !rd_valid,
             "R1 first cycle after reset", DW'({ras_n, cas_n, dq_oe, req_ready}), DW'(4'b1100));

        // R3: write then read the same row: one activation only.
        f0 = ras_falls;
        issue(1, {12'd5, 10'd3}, 72'h1234_5678_9ABC_DEF0_11);
        issue(0, {12'd5, 10'd3}, '0);
        repeat (12) @(negedge clk);
        tchk(ras_falls - f0 == 1, "R3 page hit keeps row", DW'(ras_falls - f0), 1);

        // R4: different row forces close, precharge, reactivation.
        f0 = ras_falls;
        issue(0, {12'd9, 10'd1}, '0);
        issue(1, {12'd9, 10'd2}, 72'hFEDC_BA98_7654_3210_AA);   // R8 read-then-write
        issue(0, {12'd9, 10'd2}, '0);
        repeat (12) @(negedge clk);
        tchk(ras_falls - f0 == 1, "R4 row miss activates once", DW'(ras_falls - f0), 1);

        // R10: refresh request blocks a pending hit and waits for precharge.
        @(negedge clk);
        ref_req = 1; req_valid = 1; req_write = 0; req_addr = {12'd9, 10'd4};
        for (int i = 0; i < 30 && !ref_ack; i++) begin
            #1; tchk(!req_ready, "R10 no accept during refresh request", DW'(req_ready), 0);
            @(negedge clk);
        end
        tchk(ref_ack && ras_n, "R10 acknowledge with bank closed", DW'({ref_ack, ras_n}), DW'(2'b11));
        tchk(ras_hi + 1 >= T_RP, "R10 acknowledge after precharge", DW'(ras_hi + 1), DW'(T_RP));
        repeat (3) begin
            @(negedge clk); #1;
            tchk(!req_ready && ras_n, "R10 bank held closed", DW'({req_ready, ras_n}), DW'(2'b01));
        end
        req_valid = 0; ref_req = 0;
        issue(0, {12'd9, 10'd4}, '0);

        // R9: idle open row is closed before the limit.
        repeat (T_RAS_MAX + 20) @(negedge clk);
        tchk(ras_n, "R9 idle row closed by timeout", DW'(ras_n), 1);

        // R9: steady hits still force periodic closes.
        f0 = ras_falls;
        for (int i = 0; i < 30; i++) issue(0, {12'd7, CW'($urandom)}, '0);
        repeat (12) @(negedge clk);
        f1 = ras_falls - f0;
        tchk(f1 >= 3, "R9 hit stream reopens row", DW'(f1), 3);

        // Mixed random traffic with occasional refresh.
        for (int i = 0; i < 400; i++) begin
            if ($urandom % 40 == 0) begin
                @(negedge clk); ref_req = 1;
                while (!ref_ack) @(negedge clk);
                @(negedge clk); ref_req = 0;
            end
            issue($urandom % 2 == 1, {rnd_row(), CW'($urandom % 8)}, rnd_data());
        end
        for (int i = 0; i < 500 && rd_idx < rd_issued; i++) @(negedge clk);
        tchk(rd_idx == rd_issued, "R12 every read returned once", DW'(rd_idx), DW'(rd_issued));

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", t_checks + m_checks, t_fail + m_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==",
                     t_checks + m_checks + 1, t_fail + m_fail + 1);
            $finish;
        end
    end

endmodule